// File: doc/BRIEF.md
# Single-Clock Position-Counting FIFO

This block is a single-clock first-in, first-out buffer, 32 bits wide and 512 words deep. It behaves like a hard memory FIFO primitive. A producer offers a word by raising the write enable together with the write data. A consumer raises the read enable and gets the oldest stored word on the read data port in the next clock cycle.

Besides the empty and full flags, the block reports two threshold flags. They mark a nearly full buffer and a nearly drained buffer, and their distances from the ends are set by parameters. The block does not report a fill level. It shows the write and read positions as wrapping address counters instead. An access that cannot be served is dropped, and a registered error flag reports it for one cycle per offending request. Depth must be a power of two, so that the position counters wrap on the buffer boundary.

Top module: `posfifo_top`

## Requirements
- R1: While reset is held and right after it is released: isEmpty=1, nearEmpty=1, isFull=0, nearFull=0, wrPos=0, rdPos=0, wrReject=0, rdReject=0, rdData=0.
- R2: Accepted words leave in the order they were accepted. The word for an accepted read is on rdData from the clock edge that samples rdEn, and rdData holds its value until the next accepted read.
- R3: wrPos advances by one on every accepted write and wraps from DEPTH-1 to 0. It does not move otherwise.
- R4: rdPos advances by one on every accepted read and wraps from DEPTH-1 to 0. It does not move otherwise.
- R5: isFull is 1 exactly when DEPTH words are stored, and isEmpty is 1 exactly when no word is stored.
- R6: nearFull is 1 exactly when the number of stored words is at least DEPTH-FULL_GAP (384 by default).
- R7: nearEmpty is 1 exactly when the number of stored words is at most EMPTY_GAP (128 by default).
- R8: A write requested while isFull=1 is dropped: positions, flags and stored data stay unchanged. wrReject is 1 in the following cycle. wrReject is 0 after any cycle without a rejected write.
- R9: A read requested while isEmpty=1 is dropped: positions, flags and rdData stay unchanged. rdReject is 1 in the following cycle. rdReject is 0 after any cycle without a rejected read.
- R10: When read and write are requested together on a full buffer, the read is accepted and the write is rejected. On an empty buffer, the write is accepted and the read is rejected.
- R11: When read and write are requested together with 0 < stored < DEPTH, both are accepted and the stored count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write request |
| wrData | input | 32 | Word to store |
| rdEn | input | 1 | Read request |
| rdData | output | 32 | Word returned by the last accepted read |
| isEmpty | output | 1 | No word stored |
| isFull | output | 1 | All DEPTH words stored |
| nearEmpty | output | 1 | Stored count at or below EMPTY_GAP |
| nearFull | output | 1 | Stored count at or above DEPTH-FULL_GAP |
| wrPos | output | 9 | Wrapping write position |
| rdPos | output | 9 | Wrapping read position |
| wrReject | output | 1 | Previous cycle dropped a write |
| rdReject | output | 1 | Previous cycle dropped a read |

## Verification
A corrupted fill count shows up only at the flag thresholds. It surfaces as a wrong nearEmpty or nearFull at 128 or 384 words, or as a full or empty flag that disagrees with how many words were actually put in. The bench therefore drives long biased random runs that cross every threshold in both directions. A wrong position or storage update appears on rdData at the first read of the affected slot, which can be up to 512 accepts later. For that reason every read is compared against a reference queue. An acceptance error at the ends is visible on the next cycle through the reject flags and the position counters.

// File: rtl/posfifo_pkg.sv
`timescale 1ns/1ps
package posfifo_pkg;
  // Strobes from the control half to the storage half
  typedef struct packed {
    logic wrAccept;
    logic rdAccept;
  } fifoStrobeT;
endpackage

// File: rtl/posfifo_ctrl.sv
`timescale 1ns/1ps
module posfifo_ctrl
  import posfifo_pkg::*;
#(
  parameter int DEPTH     = 512,
  parameter int EMPTY_GAP = 128,
  parameter int FULL_GAP  = 128
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wrEn,
  input  logic                       rdEn,
  output fifoStrobeT                 strobe,
  output logic [$clog2(DEPTH)-1:0]   wrPos,
  output logic [$clog2(DEPTH)-1:0]   rdPos,
  output logic                       isEmpty,
  output logic                       isFull,
  output logic                       nearEmpty,
  output logic                       nearFull,
  output logic                       wrReject,
  output logic                       rdReject
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_LVL  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HIGH_LVL  = CNT_W'(DEPTH - FULL_GAP);
  localparam logic [CNT_W-1:0] LOW_LVL   = CNT_W'(EMPTY_GAP);

  logic [CNT_W-1:0] fillCnt;

  // Full blocks writes even with a read pending; empty blocks reads likewise
  assign isEmpty         = (fillCnt == '0);
  assign isFull          = (fillCnt == FULL_LVL);
  assign nearEmpty       = (fillCnt <= LOW_LVL);
  assign nearFull        = (fillCnt >= HIGH_LVL);
  assign strobe.wrAccept = wrEn && !isFull;
  assign strobe.rdAccept = rdEn && !isEmpty;

  always_ff @(posedge clk) begin
    if (rst) begin
      fillCnt  <= '0;
      wrPos    <= '0;
      rdPos    <= '0;
      wrReject <= 1'b0;
      rdReject <= 1'b0;
    end else begin
      case ({strobe.wrAccept, strobe.rdAccept})
        2'b10:   fillCnt <= fillCnt + 1'b1;
        2'b01:   fillCnt <= fillCnt - 1'b1;
        default: fillCnt <= fillCnt;
      endcase
      if (strobe.wrAccept) wrPos <= wrPos + 1'b1;
      if (strobe.rdAccept) rdPos <= rdPos + 1'b1;
      wrReject <= wrEn && isFull;
      rdReject <= rdEn && isEmpty;
    end
  end
endmodule

// File: rtl/posfifo_data.sv
`timescale 1ns/1ps
module posfifo_data
  import posfifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 512
) (
  input  logic                      clk,
  input  logic                      rst,
  input  fifoStrobeT                strobe,
  input  logic [$clog2(DEPTH)-1:0]  wrAddr,
  input  logic [$clog2(DEPTH)-1:0]  rdAddr,
  input  logic [DATA_W-1:0]         wrData,
  output logic [DATA_W-1:0]         rdData
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.wrAccept) store[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst)                  rdData <= '0;
    else if (strobe.rdAccept) rdData <= store[rdAddr];
  end
endmodule

// File: rtl/posfifo_top.sv
`timescale 1ns/1ps
module posfifo_top
  import posfifo_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 512,
  parameter int EMPTY_GAP = 128,
  parameter int FULL_GAP  = 128
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wrEn,
  input  logic [DATA_W-1:0]         wrData,
  input  logic                      rdEn,
  output logic [DATA_W-1:0]         rdData,
  output logic                      isEmpty,
  output logic                      isFull,
  output logic                      nearEmpty,
  output logic                      nearFull,
  output logic [$clog2(DEPTH)-1:0]  wrPos,
  output logic [$clog2(DEPTH)-1:0]  rdPos,
  output logic                      wrReject,
  output logic                      rdReject
);
  fifoStrobeT strobe;

  posfifo_ctrl #(
    .DEPTH(DEPTH), .EMPTY_GAP(EMPTY_GAP), .FULL_GAP(FULL_GAP)
  ) uCtrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .strobe(strobe),
    .wrPos(wrPos), .rdPos(rdPos), .isEmpty(isEmpty), .isFull(isFull),
    .nearEmpty(nearEmpty), .nearFull(nearFull),
    .wrReject(wrReject), .rdReject(rdReject)
  );

  posfifo_data #(
    .DATA_W(DATA_W), .DEPTH(DEPTH)
  ) uData (
    .clk(clk), .rst(rst), .strobe(strobe), .wrAddr(wrPos), .rdAddr(rdPos),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/posfifo_top_chk.sv
`timescale 1ns/1ps
module posfifo_top_chk #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 512
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      wrEn,
  input logic [DATA_W-1:0]         wrData,
  input logic                      rdEn,
  input logic [DATA_W-1:0]         rdData,
  input logic                      isEmpty,
  input logic                      isFull,
  input logic                      nearEmpty,
  input logic                      nearFull,
  input logic [$clog2(DEPTH)-1:0]  wrPos,
  input logic [$clog2(DEPTH)-1:0]  rdPos,
  input logic                      wrReject,
  input logic                      rdReject
);
  localparam int ADDR_W = $clog2(DEPTH);

  a_r5_not_both: assert property (@(posedge clk) disable iff (rst)
    !(isEmpty && isFull));

  a_r3_wr_step: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !isFull) |=> (wrPos == ADDR_W'($past(wrPos) + 1'b1)));

  a_r4_rd_step: assert property (@(posedge clk) disable iff (rst)
    (rdEn && !isEmpty) |=> (rdPos == ADDR_W'($past(rdPos) + 1'b1)));

  a_r6_full_implies_high: assert property (@(posedge clk) disable iff (rst)
    isFull |-> nearFull);

  a_r7_empty_implies_low: assert property (@(posedge clk) disable iff (rst)
    isEmpty |-> nearEmpty);

  a_r8_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (wrEn && isFull) |=> (wrReject && $stable(wrPos)));

  a_r9_read_dropped: assert property (@(posedge clk) disable iff (rst)
    (rdEn && isEmpty) |=> (rdReject && $stable(rdPos) && $stable(rdData)));

  a_r10_full_both: assert property (@(posedge clk) disable iff (rst)
    (isFull && wrEn && rdEn) |=> (!isFull && wrReject && !rdReject));

  a_r11_mid_both: assert property (@(posedge clk) disable iff (rst)
    (!isFull && !isEmpty && wrEn && rdEn) |=>
      ($stable(isEmpty) && $stable(isFull) && !wrReject && !rdReject));
endmodule

bind posfifo_top posfifo_top_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uChk (.*);

// File: tb/tb_posfifo_top.sv
`timescale 1ns/1ps
module tb_posfifo_top;
  localparam int DW = 32, DEPTH = 512, EGAP = 128, FGAP = 128;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, wrEn, rdEn, isEmpty, isFull, nearEmpty, nearFull, wrReject, rdReject;
  logic [DW-1:0] wrData, rdData;
  logic [8:0] wrPos, rdPos;

  posfifo_top dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .isEmpty(isEmpty), .isFull(isFull), .nearEmpty(nearEmpty),
    .nearFull(nearFull), .wrPos(wrPos), .rdPos(rdPos),
    .wrReject(wrReject), .rdReject(rdReject)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model
  logic [DW-1:0] mMem [DEPTH];
  logic [DW-1:0] mRd;
  int mCnt, mWp, mRp;
  bit mWerr, mRerr;

  function automatic bit expHigh(int cnt); return cnt >= DEPTH - FGAP; endfunction
  function automatic bit expLow(int cnt);  return cnt <= EGAP;         endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkAll();
    chk("R2", "rdData",    64'(rdData),    64'(mRd));
    chk("R3", "wrPos",     64'(wrPos),     64'(mWp));
    chk("R4", "rdPos",     64'(rdPos),     64'(mRp));
    chk("R5", "isFull",    64'(isFull),    64'(mCnt == DEPTH));
    chk("R5", "isEmpty",   64'(isEmpty),   64'(mCnt == 0));
    chk("R6", "nearFull",  64'(nearFull),  64'(expHigh(mCnt)));
    chk("R7", "nearEmpty", 64'(nearEmpty), 64'(expLow(mCnt)));
    chk("R8", "wrReject",  64'(wrReject),  64'(mWerr));
    chk("R9", "rdReject",  64'(rdReject),  64'(mRerr));
  endtask

  task automatic step(bit we, logic [DW-1:0] wd, bit re);
    bit accW, accR;
    wrEn = we; wrData = wd; rdEn = re;
    @(posedge clk); #1;
    accW  = we && (mCnt < DEPTH);
    accR  = re && (mCnt > 0);
    mWerr = we && (mCnt == DEPTH);
    mRerr = re && (mCnt == 0);
    if (accR) begin mRd = mMem[mRp]; mRp = (mRp + 1) % DEPTH; end
    if (accW) begin mMem[mWp] = wd; mWp = (mWp + 1) % DEPTH; end
    mCnt = mCnt + int'(accW) - int'(accR);
    checkAll();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int p0, p1;
    void'($urandom(32'd20240611));
    rst = 1'b1; wrEn = 1'b0; rdEn = 1'b0; wrData = '0;
    mCnt = 0; mWp = 0; mRp = 0; mRd = '0; mWerr = 0; mRerr = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: values while reset is held
    chk("R1", "isEmpty",   64'(isEmpty),   64'd1);
    chk("R1", "nearEmpty", 64'(nearEmpty), 64'd1);
    chk("R1", "isFull",    64'(isFull),    64'd0);
    chk("R1", "nearFull",  64'(nearFull),  64'd0);
    chk("R1", "wrPos",     64'(wrPos),     64'd0);
    chk("R1", "rdPos",     64'(rdPos),     64'd0);
    chk("R1", "wrReject",  64'(wrReject),  64'd0);
    chk("R1", "rdReject",  64'(rdReject),  64'd0);
    chk("R1", "rdData",    64'(rdData),    64'd0);
    rst = 1'b0;
    step(0, '0, 0);

    // fill to the top, crossing both thresholds; R3 wrap on the last write
    for (int i = 0; i < DEPTH; i++) step(1, $urandom(), 0);
    chk("R3", "wrPos wrapped", 64'(wrPos), 64'd0);
    chk("R5", "full after DEPTH writes", 64'(isFull), 64'd1);

    // R8: writes on a full buffer, then an idle cycle clears the flag
    step(1, 32'hDEAD_0001, 0);
    step(1, 32'hDEAD_0002, 0);
    chk("R8", "wrPos held", 64'(wrPos), 64'd0);
    step(0, '0, 0);
    chk("R8", "wrReject cleared", 64'(wrReject), 64'd0);

    // R10: both on full
    step(1, 32'hDEAD_0003, 1);
    chk("R10", "full both: wrReject", 64'(wrReject), 64'd1);
    chk("R10", "full both: rdPos",    64'(rdPos),    64'd1);
    chk("R10", "full both: isFull",   64'(isFull),   64'd0);

    // drain; R4 wrap when the last word leaves
    while (mCnt > 0) step(0, '0, 1);
    chk("R4", "rdPos wrapped", 64'(rdPos), 64'd0);

    // R9: reads on an empty buffer
    step(0, '0, 1);
    step(0, '0, 1);
    chk("R9", "rdPos held", 64'(rdPos), 64'd0);

    // R10: both on empty
    step(1, 32'h0BAD_F00D, 1);
    chk("R10", "empty both: rdReject", 64'(rdReject), 64'd1);
    chk("R10", "empty both: isEmpty",  64'(isEmpty),  64'd0);
    chk("R10", "empty both: wrPos",    64'(wrPos),    64'd1);

    // R11: both at a mid level
    for (int i = 0; i < 199; i++) step(1, $urandom(), 0);
    p0 = int'(wrPos); p1 = int'(rdPos);
    step(1, 32'h1234_5678, 1);
    chk("R11", "mid both: wrPos", 64'(wrPos), 64'((p0 + 1) % DEPTH));
    chk("R11", "mid both: rdPos", 64'(rdPos), 64'((p1 + 1) % DEPTH));
    chk("R11", "mid both: count", 64'(mCnt),  64'd200);

    // biased random phases that alternately fill and drain
    for (int ph = 0; ph < 6; ph++) begin
      for (int i = 0; i < 2000; i++) begin
        int r;
        bit we, re;
        r  = int'($urandom_range(99));
        we = (ph % 2 == 0) ? (r < 75) : (r < 25);
        r  = int'($urandom_range(99));
        re = (ph % 2 == 0) ? (r < 30) : (r < 70);
        step(we, $urandom(), re);
      end
    end

    // final drain to check remaining order
    while (mCnt > 0) step(0, '0, 1);
    step(0, '0, 1);

    done = 1;
    summary();
    $finish;
  end
endmodule